// File: doc/BRIEF.md
# Vector Unsigned Halfword Greater-Than Compare Unit

This unit executes one packed vector compare instruction. A 32-bit instruction word arrives with two 128-bit source vectors that were already read from the vector register file, together with a valid strobe. The unit checks that the word encodes the unsigned halfword greater-than compare and, if so, splits both vectors into eight unsigned 16-bit lanes and produces a per-lane mask. A lane is all ones where the first operand is strictly larger and all zeros elsewhere.

The mask, the destination register index and a result-valid pulse appear one clock after the instruction is accepted. When the word's record bit is set, the unit also emits a 4-bit condition summary with a write enable for condition field 6. The summary says whether every lane compared true or every lane compared false. The unit also decodes the two source register indices as combinational read addresses, so the register file can fetch operands in the same cycle. The unit never touches saturation, carry or overflow status and never raises an exception.

Top module: `vcmp_uh_unit`

## Requirements
- R1: Lane i (i = 0..7) occupies vector bits [127-16*i : 112-16*i], so lane 0 is the most significant halfword. Result lane i is 16'hFFFF when source A lane i is greater than source B lane i as unsigned numbers, and 16'h0000 otherwise (for example, A = 16'hFFFF against B = 16'h0001 gives 16'hFFFF).
- R2: A lane in which A equals B gives 16'h0000.
- R3: A word is accepted only when instrValid is high, bits [31:26] equal 4 and bits [9:0] equal 582 (10'h246). A valid word that fails either match produces neither resValid nor condWe.
- R4: srcAIdx is instrWord[20:16] and srcBIdx is instrWord[15:11], both combinational. The registered dstIdx is instrWord[25:21] of the accepted word.
- R5: resMask and dstIdx are presented, and resValid is high, in the cycle after acceptance. resValid is high for exactly one cycle for each accepted word, including back-to-back words.
- R6: instrWord[10] is the record bit. When it is set on an accepted word, condWe is high together with resValid. When it is clear, condWe stays low.
- R7: condVal bit 3 is set when every lane compared true and bit 1 is set when every lane compared false. Bits 2 and 0 are always 0. condVal changes only on accepted words that have the record bit set.
- R8: The operands are sampled in the cycle of acceptance. A later change of srcA or srcB, as happens when the destination register is also a source, does not alter the presented result.
- R9: resMask and dstIdx hold their values until the next accepted word. Rejected words and idle cycles leave them unchanged.
- R10: During reset (active-low rstN), resValid, condWe, resMask, dstIdx and condVal are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word and operands are valid this cycle |
| instrWord | input | 32 | Instruction word |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| srcAIdx | output | 5 | Register index of the first source (combinational) |
| srcBIdx | output | 5 | Register index of the second source (combinational) |
| dstIdx | output | 5 | Destination register index of the last accepted word |
| resMask | output | 128 | Per-lane compare mask |
| resValid | output | 1 | One-cycle pulse announcing a new result |
| condWe | output | 1 | Write enable for condition field 6 |
| condVal | output | 4 | Condition summary {all true, 0, all false, 0} |

## Verification
The mask, destination index, result pulse and condition outputs are all due exactly one clock after the word is driven. The source index outputs are due in the same cycle, a moment after the inputs settle. The driver changes inputs on falling edges and queues one expected item for each word the model accepts. A monitor compares on each falling edge: a resValid that finds no queued item, or a queued item that is still waiting after its cycle, counts as a failure. The same-cycle index checks are made by the driver itself, after the drive has settled.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  // Strobes from the control path to the lane datapath
  typedef struct packed {
    logic load;    // capture a new mask from the current operands
    logic record;  // also capture a new condition summary
  } vcmpCtrl_t;
endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 5,
  parameter int OPC_W   = 6,
  parameter int PRIM_OP = 4,
  parameter int EXT_OP  = 582
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output vcmpCtrl_t        ctrl,
  output logic [IDX_W-1:0] srcAIdx,
  output logic [IDX_W-1:0] srcBIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic             resValid,
  output logic             condWe
);
  // Field positions, counted down from the most significant bit
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int VD_LSB  = OPC_LSB - IDX_W;
  localparam int VA_LSB  = VD_LSB - IDX_W;
  localparam int VB_LSB  = VA_LSB - IDX_W;
  localparam int RC_POS  = VB_LSB - 1;
  localparam int XO_W    = RC_POS;
  localparam logic [OPC_W-1:0] PRIM_VAL = PRIM_OP[OPC_W-1:0];
  localparam logic [XO_W-1:0]  EXT_VAL  = EXT_OP[XO_W-1:0];

  logic [OPC_W-1:0] opField;
  logic [XO_W-1:0]  xoField;
  logic [IDX_W-1:0] vdField;
  logic             recBit;
  logic             accept;

  assign opField = instrWord[WORD_W-1 -: OPC_W];
  assign vdField = instrWord[VD_LSB +: IDX_W];
  assign srcAIdx = instrWord[VA_LSB +: IDX_W];
  assign srcBIdx = instrWord[VB_LSB +: IDX_W];
  assign recBit  = instrWord[RC_POS];
  assign xoField = instrWord[XO_W-1:0];

  assign accept      = instrValid && (opField == PRIM_VAL) && (xoField == EXT_VAL);
  assign ctrl.load   = accept;
  assign ctrl.record = accept && recBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      condWe   <= 1'b0;
      dstIdx   <= '0;
    end else begin
      resValid <= accept;
      condWe   <= accept && recBit;
      if (accept) dstIdx <= vdField;
    end
  end

  // R5: a result pulse always traces back to a valid strobe one cycle earlier
  p_pulse_after_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(instrValid));

  // R6: the condition write never appears without a result
  p_cond_with_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    condWe |-> resValid);

  // R3: a presented result came from a word with the right primary opcode
  p_opcode_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($past(instrWord[WORD_W-1 -: OPC_W]) == PRIM_VAL));

  // R9: with no result pulse the destination index holds
  p_dst_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(dstIdx));
endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes
  import vcmp_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vcmpCtrl_t               ctrl,
  input  logic [LANE_W*LANES-1:0] srcA,
  input  logic [LANE_W*LANES-1:0] srcB,
  output logic [LANE_W*LANES-1:0] resMask,
  output logic [3:0]              condVal
);
  localparam int VEC_W = LANE_W * LANES;

  logic [LANES-1:0] laneHit;

  // Lane 0 is the most significant halfword
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = VEC_W - 1 - LANE_W * i;
    logic [LANE_W-1:0] aLane;
    logic [LANE_W-1:0] bLane;
    assign aLane      = srcA[HI -: LANE_W];
    assign bLane      = srcB[HI -: LANE_W];
    assign laneHit[i] = aLane > bLane;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          resMask[HI -: LANE_W] <= '0;
      else if (ctrl.load) resMask[HI -: LANE_W] <= {LANE_W{laneHit[i]}};
    end
  end

  // Summary order from bit 3 down: all true, greater (0), all false, summary overflow (0)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            condVal <= '0;
    else if (ctrl.record) condVal <= {&laneHit, 1'b0, ~|laneHit, 1'b0};
  end

  // R7: the all-true summary bit agrees with the registered mask
  p_all_true_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.record) |-> (condVal[3] == (resMask == {VEC_W{1'b1}})));

  // R7: the all-false summary bit agrees with the registered mask
  p_all_false_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.record) |-> (condVal[1] == (resMask == {VEC_W{1'b0}})));

  // R9: without a load the mask holds
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.load) |-> $stable(resMask));
endmodule

// File: rtl/vcmp_uh_unit.sv
module vcmp_uh_unit
  import vcmp_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 8,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    instrValid,
  input  logic [WORD_W-1:0]       instrWord,
  input  logic [LANE_W*LANES-1:0] srcA,
  input  logic [LANE_W*LANES-1:0] srcB,
  output logic [IDX_W-1:0]        srcAIdx,
  output logic [IDX_W-1:0]        srcBIdx,
  output logic [IDX_W-1:0]        dstIdx,
  output logic [LANE_W*LANES-1:0] resMask,
  output logic                    resValid,
  output logic                    condWe,
  output logic [3:0]              condVal
);
  vcmpCtrl_t ctrl;

  vcmp_ctrl #(
    .WORD_W(WORD_W),
    .IDX_W (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .instrWord (instrWord),
    .ctrl      (ctrl),
    .srcAIdx   (srcAIdx),
    .srcBIdx   (srcBIdx),
    .dstIdx    (dstIdx),
    .resValid  (resValid),
    .condWe    (condWe)
  );

  vcmp_lanes #(
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) lanes_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .resMask(resMask),
    .condVal(condVal)
  );
endmodule

// File: tb/vcmp_uh_unit_tb_top.sv
`timescale 1ns/1ps
module vcmp_uh_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instrValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic [4:0]   srcAIdx, srcBIdx, dstIdx;
  logic [127:0] resMask;
  logic         resValid, condWe;
  logic [3:0]   condVal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] mask;
    logic [4:0]   dst;
    logic         rec;
    logic [3:0]   cond;
  } expItem_t;

  expItem_t     sbQ[$];
  logic [3:0]   lastCond = '0;
  logic [127:0] lastMask = '0;
  logic [4:0]   lastDst  = '0;

  always #2 clk = ~clk;

  vcmp_uh_unit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .srcA(srcA), .srcB(srcB), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .dstIdx(dstIdx), .resMask(resMask), .resValid(resValid),
    .condWe(condWe), .condVal(condVal)
  );

  function automatic logic [31:0] mkWord(bit rec, logic [4:0] vd, logic [4:0] va, logic [4:0] vb);
    return {6'd4, vd, va, vb, rec, 10'd582};
  endfunction

  function automatic logic [127:0] refMask(logic [127:0] a, logic [127:0] b);
    logic [127:0] m = '0;
    for (int i = 0; i < 8; i++)
      m[127-16*i -: 16] = (a[127-16*i -: 16] > b[127-16*i -: 16]) ? 16'hFFFF : 16'h0000;
    return m;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one word per falling edge, expected items queued for accepted words
  task automatic issue(logic [31:0] w, logic [127:0] a, logic [127:0] b);
    expItem_t it;
    bit acc;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w; srcA = a; srcB = b;
    acc = (w[31:26] == 6'd4) && (w[9:0] == 10'd582);
    if (acc) begin
      it.mask = refMask(a, b);
      it.dst  = w[25:21];
      it.rec  = w[10];
      if (w[10]) lastCond = {(it.mask == '1), 1'b0, (it.mask == '0), 1'b0};
      it.cond = lastCond;
      sbQ.push_back(it);
    end
    #1;
    check("R4 srcAIdx", 128'(srcAIdx), 128'(w[20:16]));
    check("R4 srcBIdx", 128'(srcBIdx), 128'(w[15:11]));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instrValid = 1'b0;
    end
  endtask

  // Monitor: compare at each falling edge, one cycle after the drive
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (resValid) begin
          if (sbQ.size() == 0) begin
            check("R3 unexpected resValid", 128'(resValid), 128'(0));
          end else begin
            it = sbQ.pop_front();
            check("R1 R2 R5 resMask", resMask, it.mask);
            check("R4 dstIdx", 128'(dstIdx), 128'(it.dst));
            check("R6 condWe", 128'(condWe), 128'(it.rec));
            check("R7 condVal", 128'(condVal), 128'(it.cond));
            lastMask = it.mask; lastDst = it.dst;
          end
        end else begin
          if (sbQ.size() != 0) begin
            check("R5 missing resValid", 128'(resValid), 128'(1));
            void'(sbQ.pop_front());
          end
          if (condWe !== 1'b0) check("R6 condWe without result", 128'(condWe), 128'(0));
          check("R9 resMask hold", resMask, lastMask);
          check("R9 dstIdx hold", 128'(dstIdx), 128'(lastDst));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] mixA, mixB, aliasA;
    mixA   = {16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF, 16'h1234, 16'h0000, 16'hABCD, 16'h0010};
    mixB   = {16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'h0000, 16'hABCC, 16'h0011};
    aliasA = {8{16'h5555}};

    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 resValid", 128'(resValid), 128'(0));
    check("R10 condWe", 128'(condWe), 128'(0));
    check("R10 resMask", resMask, '0);
    check("R10 dstIdx", 128'(dstIdx), 128'(0));
    check("R10 condVal", 128'(condVal), 128'(0));
    rstN = 1'b1;
    idle(2);

    // R1 R7: all lanes true, recorded
    issue(mkWord(1, 5'd3, 5'd1, 5'd2), {8{16'hFFFF}}, {8{16'h0001}});
    idle(1);
    // R2 R7: equal lanes give zero, recorded (all false)
    issue(mkWord(1, 5'd7, 5'd4, 5'd4), {8{16'h9999}}, {8{16'h9999}});
    idle(1);
    // R1 R2: mixed lanes including unsigned corner, no record
    issue(mkWord(0, 5'd31, 5'd8, 5'd9), mixA, mixB);
    idle(1);
    // R5 R6: back-to-back words, mixed record bits
    issue(mkWord(1, 5'd10, 5'd0, 5'd1), mixB, mixA);
    issue(mkWord(0, 5'd11, 5'd2, 5'd3), {8{16'h0000}}, {8{16'hFFFF}});
    issue(mkWord(1, 5'd12, 5'd5, 5'd6), mixA, mixB);
    idle(1);
    // R3 R9: rejected words, wrong primary and wrong extended opcode
    issue({6'd5, mkWord(1, 5'd20, 5'd1, 5'd2)[25:0]}, {8{16'hFFFF}}, '0);
    issue({mkWord(1, 5'd21, 5'd1, 5'd2)[31:10], 10'd583}, {8{16'hFFFF}}, '0);
    issue(32'h10000246 ^ 32'h0000_0040, '0, {8{16'hFFFF}});
    idle(2);
    // R8: destination aliases source A; operands change the cycle after
    issue(mkWord(1, 5'd6, 5'd6, 5'd2), aliasA, {8{16'h4444}});
    @(negedge clk);
    instrValid = 1'b0; srcA = '0; srcB = {8{16'hFFFF}};
    idle(2);
    // R7: record clear keeps the last summary even though lanes differ
    issue(mkWord(0, 5'd1, 5'd1, 5'd1), {8{16'h0000}}, {8{16'h0001}});
    idle(3);

    check("R5 queue drained", 128'(sbQ.size()), 128'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule